// File: doc/BRIEF.md
# RV32I Decode Stage with Early Branch Resolution

This block is the decode stage of a five-stage RV32I pipeline. Each cycle it accepts one 32-bit instruction with its program counter. It extracts the register indices and drives the two register-file read addresses. The read data come back in the same cycle on input ports. The block builds the sign-extended immediate for the instruction's format and selects the execute-stage operand sources. It also produces the memory read/write enables and the register write enable. All execute-bound fields are registered.

Conditional branches and JAL are resolved here rather than in execute. The block compares the two register operands in the decode cycle. It raises a redirect flag with the target address combinationally, so fetch can change its next PC at the following edge. Forwarding, trap and control-register logic are outside this block.

Top module: `rv_decode_stage`

## Requirements
- R1: The read address rf_rs1_addr is in_instr[19:15] for the register-register (0x33), OP-IMM (0x13), load (0x03), store (0x23) and branch (0x63) opcodes. The read address rf_rs2_addr is in_instr[24:20] for 0x33, 0x23 and 0x63. In every other case each address is 0. Both addresses are combinational.
- R2: Opcode 0x33 registers ex_op1_sel = 0 (register rs1), ex_op2_sel = 0 (register rs2) and ex_imm = 0.
- R3: Opcodes 0x13 and 0x03 register ex_imm = sign-extended in_instr[31:20] and ex_op2_sel = 1 (immediate). Opcode 0x03 also raises ex_mem_rd_en.
- R4: Opcode 0x23 registers ex_imm = sign-extended {in_instr[31:25], in_instr[11:7]}, ex_op2_sel = 1 and ex_mem_wr_en = 1. It carries rf_rs2_data to ex_store_data. The two memory enables are never high together.
- R5: AUIPC (0x17) reads no registers and registers ex_imm = {in_instr[31:12], 12'b0}, ex_op1_sel = 1 (PC) and ex_op2_sel = 1. LUI (0x37) registers the same immediate with ex_op1_sel = 2 (zero).
- R6: For branch opcode 0x63, funct3 = in_instr[14:12] selects the test. Code 0 tests equal and code 1 tests not equal. Codes 4 and 5 are signed less-than and greater-or-equal. Codes 6 and 7 are unsigned less-than and greater-or-equal. When the test holds, fetch_redirect is high in the same cycle and fetch_target = in_pc + B-immediate. Codes 2 and 3 never redirect. The registered operands are ex_op1_sel = 1 and ex_op2_sel = 1.
- R7: JAL (0x6f) always raises fetch_redirect with fetch_target = in_pc + sign-extended J-immediate. It registers ex_op1_sel = 1 and ex_op2_sel = 2 (constant four) as the link computation.
- R8: Stores and branches register ex_reg_wr_en = 0. Opcodes 0x33, 0x13, 0x03, 0x17, 0x37 and 0x6f register ex_reg_wr_en = 1, subject to R9.
- R9: When in_instr[11:7] (rd) is 0, ex_reg_wr_en is 0.
- R10: ex_valid follows in_valid one cycle later. When in_valid is low, fetch_redirect is low and all three enables register as 0. Reset clears ex_valid and the enables.
- R11: Any other opcode registers ex_valid = in_valid with all enables 0, both selects 0 and ex_imm = 0. It reads no registers and does not redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_instr | input | 32 | Instruction word |
| in_pc | input | XLEN | PC of the instruction |
| rf_rs1_addr | output | REG_AW | First register-file read address |
| rf_rs2_addr | output | REG_AW | Second register-file read address |
| rf_rs1_data | input | XLEN | First read data |
| rf_rs2_data | input | XLEN | Second read data |
| fetch_redirect | output | 1 | Taken branch or JAL, same cycle |
| fetch_target | output | XLEN | Redirect address |
| ex_valid | output | 1 | Registered instruction valid |
| ex_rd | output | REG_AW | Destination register |
| ex_imm | output | XLEN | Sign-extended immediate |
| ex_pc | output | XLEN | PC of the registered instruction |
| ex_op1_sel | output | 2 | 0 rs1, 1 PC, 2 zero |
| ex_op2_sel | output | 2 | 0 rs2, 1 immediate, 2 constant four |
| ex_rs1_data | output | XLEN | Registered first operand |
| ex_store_data | output | XLEN | Registered second operand / store data |
| ex_mem_rd_en | output | 1 | Load enable |
| ex_mem_wr_en | output | 1 | Store enable |
| ex_reg_wr_en | output | 1 | Register write enable |

## Verification
In one cycle the block resolves a branch or JAL redirect combinationally and also registers the previous instruction's execute fields. The bench therefore runs back-to-back instruction streams. A JAL or taken branch directly follows an instruction with different enables, and the bench checks both the live redirect and the registered fields of the predecessor in that cycle. Branch operands are drawn equal about a quarter of the time, and with mixed sign bits otherwise. This exercises the signed and unsigned compare boundaries. A behavioural model built from integer arithmetic is compared with every output on every clock.

// File: rtl/rvd_pkg.sv
package rvd_pkg;
  localparam int ILEN = 32;

  localparam logic [6:0] OPC_REG    = 7'h33;
  localparam logic [6:0] OPC_IMM    = 7'h13;
  localparam logic [6:0] OPC_LOAD   = 7'h03;
  localparam logic [6:0] OPC_STORE  = 7'h23;
  localparam logic [6:0] OPC_BRANCH = 7'h63;
  localparam logic [6:0] OPC_AUIPC  = 7'h17;
  localparam logic [6:0] OPC_LUI    = 7'h37;
  localparam logic [6:0] OPC_JAL    = 7'h6f;

  typedef enum logic [1:0] {OP1_RS1 = 2'd0, OP1_PC = 2'd1, OP1_ZERO = 2'd2} op1_sel_e;
  typedef enum logic [1:0] {OP2_RS2 = 2'd0, OP2_IMM = 2'd1, OP2_FOUR = 2'd2} op2_sel_e;
  typedef enum logic [2:0] {FMT_NONE, FMT_I, FMT_S, FMT_B, FMT_U, FMT_J} fmt_e;

  typedef struct packed {
    fmt_e     fmt;
    op1_sel_e op1;
    op2_sel_e op2;
    logic     mem_rd;
    logic     mem_wr;
    logic     reg_wr;
    logic     use_rs1;
    logic     use_rs2;
    logic     is_branch;
    logic     is_jal;
  } ctrl_t;
endpackage

// File: rtl/rvd_ctrl_gen.sv
module rvd_ctrl_gen
  import rvd_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [6:0]        opcode,
  input  logic [REG_AW-1:0] rd,
  output ctrl_t             ctrl
);
  logic wr_class;

  always_comb begin
    ctrl = '{fmt: FMT_NONE, op1: OP1_RS1, op2: OP2_RS2, default: 1'b0};
    wr_class = 1'b0;
    unique case (opcode)
      OPC_REG: begin
        ctrl.use_rs1 = 1'b1;
        ctrl.use_rs2 = 1'b1;
        wr_class     = 1'b1;
      end
      OPC_IMM: begin
        ctrl.fmt     = FMT_I;
        ctrl.op2     = OP2_IMM;
        ctrl.use_rs1 = 1'b1;
        wr_class     = 1'b1;
      end
      OPC_LOAD: begin
        ctrl.fmt     = FMT_I;
        ctrl.op2     = OP2_IMM;
        ctrl.use_rs1 = 1'b1;
        ctrl.mem_rd  = 1'b1;
        wr_class     = 1'b1;
      end
      OPC_STORE: begin
        ctrl.fmt     = FMT_S;
        ctrl.op2     = OP2_IMM;
        ctrl.use_rs1 = 1'b1;
        ctrl.use_rs2 = 1'b1;
        ctrl.mem_wr  = 1'b1;
      end
      OPC_BRANCH: begin
        ctrl.fmt       = FMT_B;
        ctrl.op1       = OP1_PC;
        ctrl.op2       = OP2_IMM;
        ctrl.use_rs1   = 1'b1;
        ctrl.use_rs2   = 1'b1;
        ctrl.is_branch = 1'b1;
      end
      OPC_AUIPC: begin
        ctrl.fmt = FMT_U;
        ctrl.op1 = OP1_PC;
        ctrl.op2 = OP2_IMM;
        wr_class = 1'b1;
      end
      OPC_LUI: begin
        ctrl.fmt = FMT_U;
        ctrl.op1 = OP1_ZERO;
        ctrl.op2 = OP2_IMM;
        wr_class = 1'b1;
      end
      OPC_JAL: begin
        ctrl.fmt    = FMT_J;
        ctrl.op1    = OP1_PC;
        ctrl.op2    = OP2_FOUR;
        ctrl.is_jal = 1'b1;
        wr_class    = 1'b1;
      end
      default: ;
    endcase
    ctrl.reg_wr = wr_class & (rd != '0);
  end
endmodule

// File: rtl/rvd_imm_gen.sv
module rvd_imm_gen
  import rvd_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [31:7]     ibits,
  input  fmt_e            fmt,
  output logic [XLEN-1:0] imm
);
  logic [31:0] imm32;
  logic        sgn;

  assign sgn = ibits[31];

  always_comb begin
    unique case (fmt)
      FMT_I:   imm32 = {{20{sgn}}, ibits[31:20]};
      FMT_S:   imm32 = {{20{sgn}}, ibits[31:25], ibits[11:7]};
      FMT_B:   imm32 = {{19{sgn}}, sgn, ibits[7], ibits[30:25], ibits[11:8], 1'b0};
      FMT_U:   imm32 = {ibits[31:12], 12'b0};
      FMT_J:   imm32 = {{11{sgn}}, sgn, ibits[19:12], ibits[20], ibits[30:21], 1'b0};
      default: imm32 = '0;
    endcase
  end

  generate
    if (XLEN > 32) begin : g_wide
      assign imm = {{(XLEN-32){imm32[31]}}, imm32};
    end else begin : g_native
      assign imm = imm32[XLEN-1:0];
    end
  endgenerate
endmodule

// File: rtl/rvd_branch_unit.sv
module rvd_branch_unit #(
  parameter int XLEN = 32
) (
  input  logic            valid,
  input  logic            is_branch,
  input  logic            is_jal,
  input  logic [2:0]      cond,
  input  logic [XLEN-1:0] lhs,
  input  logic [XLEN-1:0] rhs,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] offset,
  output logic            redirect,
  output logic [XLEN-1:0] target
);
  logic eq, lt_s, lt_u, hit;

  assign eq   = (lhs == rhs);
  assign lt_s = ($signed(lhs) < $signed(rhs));
  assign lt_u = (lhs < rhs);

  always_comb begin
    unique case (cond)
      3'd0:    hit = eq;
      3'd1:    hit = !eq;
      3'd4:    hit = lt_s;
      3'd5:    hit = !lt_s;
      3'd6:    hit = lt_u;
      3'd7:    hit = !lt_u;
      default: hit = 1'b0;
    endcase
  end

  assign target   = pc + offset;
  assign redirect = valid & (is_jal | (is_branch & hit));
endmodule

// File: rtl/rv_decode_stage.sv
module rv_decode_stage
  import rvd_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [31:0]       in_instr,
  input  logic [XLEN-1:0]   in_pc,
  output logic [REG_AW-1:0] rf_rs1_addr,
  output logic [REG_AW-1:0] rf_rs2_addr,
  input  logic [XLEN-1:0]   rf_rs1_data,
  input  logic [XLEN-1:0]   rf_rs2_data,
  output logic              fetch_redirect,
  output logic [XLEN-1:0]   fetch_target,
  output logic              ex_valid,
  output logic [REG_AW-1:0] ex_rd,
  output logic [XLEN-1:0]   ex_imm,
  output logic [XLEN-1:0]   ex_pc,
  output logic [1:0]        ex_op1_sel,
  output logic [1:0]        ex_op2_sel,
  output logic [XLEN-1:0]   ex_rs1_data,
  output logic [XLEN-1:0]   ex_store_data,
  output logic              ex_mem_rd_en,
  output logic              ex_mem_wr_en,
  output logic              ex_reg_wr_en
);
  localparam int RD_LSB  = 7;
  localparam int RS1_LSB = 15;
  localparam int RS2_LSB = 20;

  ctrl_t             ctrl;
  logic [REG_AW-1:0] rd_idx;
  logic [XLEN-1:0]   imm;

  assign rd_idx = in_instr[RD_LSB +: REG_AW];

  rvd_ctrl_gen #(.REG_AW(REG_AW)) u_ctrl (
    .opcode (in_instr[6:0]),
    .rd     (rd_idx),
    .ctrl   (ctrl)
  );

  rvd_imm_gen #(.XLEN(XLEN)) u_imm (
    .ibits  (in_instr[31:7]),
    .fmt    (ctrl.fmt),
    .imm    (imm)
  );

  rvd_branch_unit #(.XLEN(XLEN)) u_br (
    .valid     (in_valid),
    .is_branch (ctrl.is_branch),
    .is_jal    (ctrl.is_jal),
    .cond      (in_instr[14:12]),
    .lhs       (rf_rs1_data),
    .rhs       (rf_rs2_data),
    .pc        (in_pc),
    .offset    (imm),
    .redirect  (fetch_redirect),
    .target    (fetch_target)
  );

  assign rf_rs1_addr = ctrl.use_rs1 ? in_instr[RS1_LSB +: REG_AW] : '0;
  assign rf_rs2_addr = ctrl.use_rs2 ? in_instr[RS2_LSB +: REG_AW] : '0;

  // control flops: reset
  always_ff @(posedge clk) begin
    if (rst) begin
      ex_valid     <= 1'b0;
      ex_mem_rd_en <= 1'b0;
      ex_mem_wr_en <= 1'b0;
      ex_reg_wr_en <= 1'b0;
    end else begin
      ex_valid     <= in_valid;
      ex_mem_rd_en <= in_valid & ctrl.mem_rd;
      ex_mem_wr_en <= in_valid & ctrl.mem_wr;
      ex_reg_wr_en <= in_valid & ctrl.reg_wr;
    end
  end

  // datapath flops: no reset, loaded on a valid instruction
  always_ff @(posedge clk) begin
    if (in_valid) begin
      ex_rd         <= rd_idx;
      ex_imm        <= imm;
      ex_pc         <= in_pc;
      ex_op1_sel    <= ctrl.op1;
      ex_op2_sel    <= ctrl.op2;
      ex_rs1_data   <= rf_rs1_data;
      ex_store_data <= rf_rs2_data;
    end
  end
endmodule

// File: rtl/rvd_decode_chk.sv
module rvd_decode_chk #(
  parameter int XLEN   = 32,
  parameter int REG_AW = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [31:0]       in_instr,
  input logic [REG_AW-1:0] rf_rs1_addr,
  input logic [REG_AW-1:0] rf_rs2_addr,
  input logic              fetch_redirect,
  input logic              ex_valid,
  input logic [REG_AW-1:0] ex_rd,
  input logic              ex_mem_rd_en,
  input logic              ex_mem_wr_en,
  input logic              ex_reg_wr_en
);
  AST_VALID_PIPE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (ex_valid == $past(in_valid))); // R10
  AST_IDLE_NO_REDIRECT: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> !fetch_redirect); // R10
  AST_MEM_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ex_mem_rd_en, ex_mem_wr_en})); // R4
  AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (rst)
    ex_mem_wr_en |-> !ex_reg_wr_en); // R8
  AST_X0_NO_WB: assert property (@(posedge clk) disable iff (rst)
    ex_reg_wr_en |-> (ex_rd != '0)); // R9
  AST_JAL_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_instr[6:0] == 7'h6f) |-> fetch_redirect); // R7
  AST_UPPER_NO_READ: assert property (@(posedge clk) disable iff (rst)
    (in_instr[6:0] == 7'h17) |-> (rf_rs1_addr == '0 && rf_rs2_addr == '0)); // R5
endmodule

bind rv_decode_stage rvd_decode_chk #(.XLEN(XLEN), .REG_AW(REG_AW)) chk_i (
  .clk            (clk),
  .rst            (rst),
  .in_valid       (in_valid),
  .in_instr       (in_instr),
  .rf_rs1_addr    (rf_rs1_addr),
  .rf_rs2_addr    (rf_rs2_addr),
  .fetch_redirect (fetch_redirect),
  .ex_valid       (ex_valid),
  .ex_rd          (ex_rd),
  .ex_mem_rd_en   (ex_mem_rd_en),
  .ex_mem_wr_en   (ex_mem_wr_en),
  .ex_reg_wr_en   (ex_reg_wr_en)
);

// File: tb/rv_decode_stage_tb_top.sv
`timescale 1ns/1ps
module rv_decode_stage_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_instr = '0, in_pc = '0, rf_rs1_data = '0, rf_rs2_data = '0;
  logic [4:0]  rf_rs1_addr, rf_rs2_addr, ex_rd;
  logic        fetch_redirect, ex_valid, ex_mem_rd_en, ex_mem_wr_en, ex_reg_wr_en;
  logic [31:0] fetch_target, ex_imm, ex_pc, ex_rs1_data, ex_store_data;
  logic [1:0]  ex_op1_sel, ex_op2_sel;

  int compared = 0, mismatched = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rv_decode_stage dut_i (.*);

  // expected registered state
  logic        x_valid, x_mrd, x_mwr, x_rwr;
  logic [4:0]  x_rd;
  logic [1:0]  x_op1, x_op2;
  logic [31:0] x_imm, x_pc, x_d1, x_d2;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model(input logic v, input logic [31:0] ins, input logic [31:0] pc,
                       input logic [31:0] a, input logic [31:0] b,
                       output logic [4:0] ra1, output logic [4:0] ra2,
                       output logic redir, output logic [31:0] tgt);
    logic [6:0] op;
    logic [2:0] f3;
    logic [31:0] iimm, simm, bimm, jimm, uimm;
    logic wr, hit;
    op = ins[6:0];
    f3 = ins[14:12];
    iimm = (ins[31] ? -32'd2048 : 32'd0) + 32'(ins[30:20]);
    simm = (ins[31] ? -32'd2048 : 32'd0) + 32'(ins[30:25]) * 32 + 32'(ins[11:7]);
    bimm = (ins[31] ? -32'd4096 : 32'd0) + 32'(ins[7]) * 2048 + 32'(ins[30:25]) * 32 + 32'(ins[11:8]) * 2;
    jimm = (ins[31] ? -32'd1048576 : 32'd0) + 32'(ins[19:12]) * 4096 + 32'(ins[20]) * 2048 + 32'(ins[30:21]) * 2;
    uimm = ins & 32'hFFFF_F000;
    ra1 = 0; ra2 = 0; redir = 0; tgt = 'x;
    x_mrd = 0; x_mwr = 0; wr = 0; x_op1 = 0; x_op2 = 0; x_imm = 0;
    case (op)
      7'h33: begin ra1 = ins[19:15]; ra2 = ins[24:20]; wr = 1; end
      7'h13: begin ra1 = ins[19:15]; x_op2 = 1; x_imm = iimm; wr = 1; end
      7'h03: begin ra1 = ins[19:15]; x_op2 = 1; x_imm = iimm; wr = 1; x_mrd = 1; end
      7'h23: begin ra1 = ins[19:15]; ra2 = ins[24:20]; x_op2 = 1; x_imm = simm; x_mwr = 1; end
      7'h63: begin
        ra1 = ins[19:15]; ra2 = ins[24:20]; x_op1 = 1; x_op2 = 1; x_imm = bimm;
        case (f3)
          3'd0: hit = (a == b);
          3'd1: hit = (a != b);
          3'd4: hit = ($signed(a) < $signed(b));
          3'd5: hit = ($signed(a) >= $signed(b));
          3'd6: hit = (a < b);
          3'd7: hit = (a >= b);
          default: hit = 0;
        endcase
        redir = v && hit; tgt = pc + bimm;
      end
      7'h17: begin x_op1 = 1; x_op2 = 1; x_imm = uimm; wr = 1; end
      7'h37: begin x_op1 = 2; x_op2 = 1; x_imm = uimm; wr = 1; end
      7'h6f: begin x_op1 = 1; x_op2 = 2; x_imm = jimm; wr = 1; redir = v; tgt = pc + jimm; end
      default: ;
    endcase
    x_valid = v;
    x_rwr = v && wr && (ins[11:7] != 0);
    x_mrd = v && x_mrd;
    x_mwr = v && x_mwr;
    x_rd = ins[11:7]; x_pc = pc; x_d1 = a; x_d2 = b;
  endtask

  // drive one instruction at a negative edge, check live outputs, then the registered ones
  task automatic step(input logic v, input logic [31:0] ins, input logic [31:0] pc,
                      input logic [31:0] a, input logic [31:0] b);
    logic [4:0] ra1, ra2;
    logic redir;
    logic [31:0] tgt;
    in_valid = v; in_instr = ins; in_pc = pc; rf_rs1_data = a; rf_rs2_data = b;
    model(v, ins, pc, a, b, ra1, ra2, redir, tgt);
    #1;
    chk("R1", "rs1 addr", 32'(rf_rs1_addr), 32'(ra1));
    chk("R1", "rs2 addr", 32'(rf_rs2_addr), 32'(ra2));
    chk("R6/R7", "redirect", 32'(fetch_redirect), 32'(redir));
    if (redir) chk("R6/R7", "target", fetch_target, tgt);
    @(negedge clk);
    chk("R10", "ex_valid", 32'(ex_valid), 32'(x_valid));
    chk("R3", "mem_rd", 32'(ex_mem_rd_en), 32'(x_mrd));
    chk("R4", "mem_wr", 32'(ex_mem_wr_en), 32'(x_mwr));
    chk("R8/R9", "reg_wr", 32'(ex_reg_wr_en), 32'(x_rwr));
    if (x_valid) begin
      chk("R2/R5/R11", "op1_sel", 32'(ex_op1_sel), 32'(x_op1));
      chk("R2/R3/R7", "op2_sel", 32'(ex_op2_sel), 32'(x_op2));
      chk("R3/R4/R5/R6", "imm", ex_imm, x_imm);
      chk("R8", "rd", 32'(ex_rd), 32'(x_rd));
      chk("R10", "pc", ex_pc, x_pc);
      chk("R2", "rs1 data", ex_rs1_data, x_d1);
      chk("R4", "store data", ex_store_data, x_d2);
    end
  endtask

  function automatic logic [31:0] mk(input logic [6:0] op, input logic [2:0] f3, input logic [4:0] rd,
                                     input logic [4:0] r1, input logic [4:0] r2, input logic [6:0] hi);
    return {hi, r2, r1, f3, rd, op};
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin : main
    logic [6:0] ops [10];
    ops = '{7'h33, 7'h13, 7'h03, 7'h23, 7'h63, 7'h17, 7'h37, 7'h6f, 7'h67, 7'h7f};
    repeat (3) @(negedge clk);
    // reset state, R10
    chk("R10", "reset ex_valid", 32'(ex_valid), 0);
    chk("R10", "reset mem_rd", 32'(ex_mem_rd_en), 0);
    chk("R10", "reset mem_wr", 32'(ex_mem_wr_en), 0);
    chk("R10", "reset reg_wr", 32'(ex_reg_wr_en), 0);
    rst = 0;
    // R2 add, R3 addi negative / load, R4 store
    step(1, mk(7'h33, 0, 5'd15, 5'd15, 5'd3, 7'h00), 32'h161c, 32'hffff_fff0, 32'h0040_0000);
    step(1, mk(7'h13, 0, 5'd6, 5'd6, 5'd16, 7'h7f), 32'h101c, 32'h2014, 32'h9);
    step(1, mk(7'h03, 2, 5'd10, 5'd2, 5'd4, 7'h00), 32'h1020, 32'h3fffb0, 32'h1);
    step(1, mk(7'h23, 2, 5'd8, 5'd2, 5'd1, 7'h02), 32'h15a4, 32'h3fffb0, 32'h1050);
    // R6 every compare, boundaries with sign bits; JAL right after taken branch
    for (int f = 0; f < 8; f++) begin
      step(1, mk(7'h63, 3'(f), 5'd16, 5'd5, 5'd6, 7'h00), 32'h1020, 32'h2064, 32'h2014);
      step(1, mk(7'h63, 3'(f), 5'd3, 5'd5, 5'd6, 7'h7f), 32'h2000, 32'h8000_0000, 32'h1);
      step(1, mk(7'h63, 3'(f), 5'd3, 5'd5, 5'd6, 7'h40), 32'h3000, 32'h55, 32'h55);
    end
    // R7 JAL positive and negative, R5 AUIPC and LUI, R9 rd zero, R11 unknown, R10 idle
    step(1, 32'h5500_00ef, 32'h104c, 32'h1, 32'h2);
    step(1, 32'hffdf_f0ef, 32'h4000, 32'h1, 32'h2);
    step(1, 32'h0000_1317, 32'h1014, 32'h0, 32'h0);
    step(1, 32'habcd_e2b7, 32'h1018, 32'h0, 32'h0);
    step(1, mk(7'h13, 0, 5'd0, 5'd1, 5'd2, 7'h01), 32'h5000, 32'h7, 32'h8);
    step(1, mk(7'h6f, 0, 5'd0, 5'd0, 5'd0, 7'h00), 32'h5004, 32'h7, 32'h8);
    step(1, mk(7'h7f, 3, 5'd4, 5'd1, 5'd2, 7'h11), 32'h5008, 32'h7, 32'h8);
    step(0, 32'h5500_00ef, 32'h500c, 32'h7, 32'h8);
    step(0, mk(7'h63, 0, 5'd1, 5'd1, 5'd1, 7'h00), 32'h5010, 32'h7, 32'h7);
    // random back-to-back stream
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] ins, a, b;
      ins = $urandom;
      ins[6:0] = ops[$urandom_range(0, 9)];
      a = $urandom;
      b = ($urandom_range(0, 3) == 0) ? a : $urandom;
      step($urandom_range(0, 7) != 0, ins, $urandom & 32'hffff_fffc, a, b);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule